// File: doc/BRIEF.md
# Shadow-Stack Memory Permission Checker

This block judges one already-translated memory request against the rules for shadow-stack memory. It decides whether the request faults and, if it does, which exception cause code to report. A request carries an access class and the leaf page-table permission bits. It also carries the translation mode, the privilege and virtualization state, and the machine and hypervisor shadow-stack enables. The remaining inputs are the second-stage (guest) read/write permission, the physical-protection read/write permission, the memory-attribute idempotent and swap-support flags, the low address bits and a word-width select.

A page whose leaf encoding is X=0, W=1, R=0 is a shadow-stack page when the relevant enables allow it. Shadow-stack instructions may only touch such pages. Any fault they raise is reported as a store/AMO type, including for the pop-check, which only reads. Access faults signal fatal conditions. Page faults signal conditions that software can repair. Ordinary accesses are judged only for their interaction with shadow-stack pages and reserved encodings.

The verdict is registered. It appears one cycle after the request strobe and is held until the next request.

Top module: `ss_perm_chk`

## Requirements
- R1: `rsp_valid_o` is high in exactly the cycle after each cycle with `req_valid_i` high. `fault_o` and `cause_o` change only on a request and hold otherwise. After reset, all three outputs are 0.
- R2: Class codes on `acc_i` are: 0 push, 1 pop-check, 2 swap, 3 load, 4 store/AMO, 5 fetch. `pte_xwr_i` is {X,W,R}. Value 3'b010 is a shadow-stack page when `menv_sse_i`=1 and (`virt_i`=0 or `henv_sse_i`=1). Otherwise that value is reserved. Every other W=1,R=0 value and 3'b000 are also reserved. On a paged request below machine mode, a reserved encoding gives a page fault of the access type: load 13, fetch 12, store and every shadow-stack class 15.
- R3: On a paged request below machine mode to a shadow-stack page, a load does not fault. A store gives cause 7 and a fetch gives cause 1.
- R4: `priv_i` is 0 user, 1 supervisor, 2 or 3 machine. A shadow-stack request below machine mode with `paged_i`=0 gives cause 7. A swap in machine mode always gives cause 7. A push or pop-check in machine mode skips the page and guest checks.
- R5: A push or pop-check whose address is not aligned to 4 bytes (`xlen64_i`=0) or 8 bytes (`xlen64_i`=1) gives cause 7. This check has the highest priority. The swap is not checked for alignment.
- R6: A shadow-stack request to a read-only page (3'b001) gives cause 15. To any other non-shadow-stack leaf (RW, RWX, RX, X-only) it gives cause 7. Every shadow-stack fault uses cause 7, 15 or 23.
- R7: After the page checks pass, a shadow-stack request with `virt_i`=1, `g_act_i`=1 and either guest permission missing gives cause 23. This check sits ahead of the physical checks.
- R8: After the earlier checks pass, a shadow-stack request with either physical-protection permission missing, or with `pma_idem_i`=0, gives cause 7.
- R9: After the earlier checks pass, a swap with `pma_swap_i`=0 gives cause 7. Push and pop-check do not depend on that flag.
- R10: Ordinary requests in machine mode, with `paged_i`=0, or to a valid non-shadow-stack leaf, give no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| acc_i | input | 3 | Access class |
| pte_xwr_i | input | 3 | Leaf permission bits {X,W,R} |
| paged_i | input | 1 | 1 = paged translation, 0 = bare |
| priv_i | input | 2 | Effective privilege |
| virt_i | input | 1 | Virtualization flag |
| menv_sse_i | input | 1 | Machine-level shadow-stack enable |
| henv_sse_i | input | 1 | Hypervisor-level shadow-stack enable |
| g_act_i | input | 1 | Guest-stage translation active |
| g_r_i | input | 1 | Guest-stage read permission |
| g_w_i | input | 1 | Guest-stage write permission |
| pmp_r_i | input | 1 | Physical-protection read permission |
| pmp_w_i | input | 1 | Physical-protection write permission |
| pma_idem_i | input | 1 | Memory region is idempotent |
| pma_swap_i | input | 1 | Memory region supports atomic swap |
| addr_lo_i | input | ADDR_LO_W | Low address bits |
| xlen64_i | input | 1 | 1 = 64-bit words, 0 = 32-bit |
| rsp_valid_o | output | 1 | Verdict valid |
| fault_o | output | 1 | Request faults |
| cause_o | output | 5 | Exception cause code |

## Verification
The bench builds the block with its default ADDR_LO_W=3. That is the least width that can show both 4-byte and 8-byte misalignment, so every low-address pattern for both word widths is swept.

One sweep crosses all six classes with all eight leaf encodings, both translation modes, three privileges and every enable/virtualization combination. That sweep reaches every page decision. A second sweep covers all 128 guest, physical and attribute permission patterns for each shadow-stack class on a valid page. Together the sweeps expose the full priority order.

// File: rtl/ss_perm_pkg.sv
package ss_perm_pkg;
  typedef enum logic [2:0] {
    ACC_PUSH   = 3'd0,
    ACC_POPCHK = 3'd1,
    ACC_SWAP   = 3'd2,
    ACC_LOAD   = 3'd3,
    ACC_STORE  = 3'd4,
    ACC_FETCH  = 3'd5
  } acc_e;

  typedef enum logic [1:0] {
    PG_BAD,
    PG_SS,
    PG_RO,
    PG_OTHER
  } pg_e;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CS_FETCH_AF  = 5'd1;
  localparam logic [CAUSE_W-1:0] CS_STORE_AF  = 5'd7;
  localparam logic [CAUSE_W-1:0] CS_FETCH_PF  = 5'd12;
  localparam logic [CAUSE_W-1:0] CS_LOAD_PF   = 5'd13;
  localparam logic [CAUSE_W-1:0] CS_STORE_PF  = 5'd15;
  localparam logic [CAUSE_W-1:0] CS_STORE_GPF = 5'd23;

  typedef struct packed {
    logic               fault;
    logic [CAUSE_W-1:0] cause;
  } verdict_t;
endpackage

// File: rtl/ss_page_decode.sv
module ss_page_decode
  import ss_perm_pkg::*;
(
  input  logic [2:0] xwr_i,
  input  logic       menv_sse_i,
  input  logic       henv_sse_i,
  input  logic       virt_i,
  output pg_e        pg_o
);
  logic ss_en;
  logic r, w, x;

  assign r = xwr_i[0];
  assign w = xwr_i[1];
  assign x = xwr_i[2];
  assign ss_en = menv_sse_i && (!virt_i || henv_sse_i);

  always_comb begin
    if (xwr_i == 3'b000)       pg_o = PG_BAD;
    else if (w && !r)          pg_o = (!x && ss_en) ? PG_SS : PG_BAD;
    else if (xwr_i == 3'b001)  pg_o = PG_RO;
    else                       pg_o = PG_OTHER;
  end

  always_comb begin
    if (pg_o == PG_SS)
      assert_ss_needs_enable_R2: assert (ss_en && xwr_i == 3'b010);
  end
endmodule

// File: rtl/ss_ss_check.sv
module ss_ss_check
  import ss_perm_pkg::*;
#(
  parameter int ADDR_LO_W = 3
) (
  input  acc_e                 acc_i,
  input  pg_e                  pg_i,
  input  logic                 paged_i,
  input  logic                 m_mode_i,
  input  logic                 virt_i,
  input  logic                 g_act_i,
  input  logic                 g_r_i,
  input  logic                 g_w_i,
  input  logic                 pmp_r_i,
  input  logic                 pmp_w_i,
  input  logic                 idem_i,
  input  logic                 swap_ok_i,
  input  logic                 xlen64_i,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  output verdict_t             vd_o
);
  localparam logic [ADDR_LO_W-1:0] MASK32 = ADDR_LO_W'(3);
  localparam logic [ADDR_LO_W-1:0] MASK64 = ADDR_LO_W'(7);

  logic is_swap, misalign, mode_af, page_pf, page_af, g_gpf, pm_af;

  assign is_swap  = (acc_i == ACC_SWAP);
  assign misalign = !is_swap && (|(addr_lo_i & (xlen64_i ? MASK64 : MASK32)));
  assign mode_af  = m_mode_i ? is_swap : !paged_i;
  assign page_pf  = !m_mode_i && (pg_i == PG_BAD || pg_i == PG_RO);
  assign page_af  = !m_mode_i && (pg_i == PG_OTHER);
  assign g_gpf    = !m_mode_i && virt_i && g_act_i && !(g_r_i && g_w_i);
  assign pm_af    = !(pmp_r_i && pmp_w_i) || !idem_i || (is_swap && !swap_ok_i);

  // fixed priority: alignment/mode, page type, guest stage, physical
  always_comb begin
    vd_o = '0;
    if (misalign || mode_af)  vd_o = '{fault: 1'b1, cause: CS_STORE_AF};
    else if (page_pf)         vd_o = '{fault: 1'b1, cause: CS_STORE_PF};
    else if (page_af)         vd_o = '{fault: 1'b1, cause: CS_STORE_AF};
    else if (g_gpf)           vd_o = '{fault: 1'b1, cause: CS_STORE_GPF};
    else if (pm_af)           vd_o = '{fault: 1'b1, cause: CS_STORE_AF};
  end

  always_comb begin
    if (misalign)
      assert_misalign_af_R5: assert (vd_o.fault && vd_o.cause == CS_STORE_AF);
    if (vd_o.fault)
      assert_store_type_R6: assert (vd_o.cause == CS_STORE_AF ||
                                    vd_o.cause == CS_STORE_PF ||
                                    vd_o.cause == CS_STORE_GPF);
  end
endmodule

// File: rtl/ss_plain_check.sv
module ss_plain_check
  import ss_perm_pkg::*;
(
  input  acc_e     acc_i,
  input  pg_e      pg_i,
  input  logic     paged_i,
  input  logic     m_mode_i,
  output verdict_t vd_o
);
  logic [CAUSE_W-1:0] pf_cause;

  always_comb begin
    case (acc_i)
      ACC_LOAD:  pf_cause = CS_LOAD_PF;
      ACC_STORE: pf_cause = CS_STORE_PF;
      default:   pf_cause = CS_FETCH_PF;
    endcase
  end

  always_comb begin
    vd_o = '0;
    if (!m_mode_i && paged_i) begin
      if (pg_i == PG_BAD) vd_o = '{fault: 1'b1, cause: pf_cause};
      else if (pg_i == PG_SS) begin
        if (acc_i == ACC_STORE)      vd_o = '{fault: 1'b1, cause: CS_STORE_AF};
        else if (acc_i != ACC_LOAD)  vd_o = '{fault: 1'b1, cause: CS_FETCH_AF};
      end
    end
  end

  always_comb begin
    if (acc_i == ACC_LOAD && pg_i == PG_SS)
      assert_load_reads_ss_R3: assert (!vd_o.fault);
  end
endmodule

// File: rtl/ss_perm_chk.sv
module ss_perm_chk
  import ss_perm_pkg::*;
#(
  parameter int ADDR_LO_W = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [2:0]           acc_i,
  input  logic [2:0]           pte_xwr_i,
  input  logic                 paged_i,
  input  logic [1:0]           priv_i,
  input  logic                 virt_i,
  input  logic                 menv_sse_i,
  input  logic                 henv_sse_i,
  input  logic                 g_act_i,
  input  logic                 g_r_i,
  input  logic                 g_w_i,
  input  logic                 pmp_r_i,
  input  logic                 pmp_w_i,
  input  logic                 pma_idem_i,
  input  logic                 pma_swap_i,
  input  logic [ADDR_LO_W-1:0] addr_lo_i,
  input  logic                 xlen64_i,
  output logic                 rsp_valid_o,
  output logic                 fault_o,
  output logic [CAUSE_W-1:0]   cause_o
);
  acc_e     acc;
  pg_e      pg;
  logic     m_mode, is_ss;
  verdict_t vd_ss, vd_plain, vd;

  assign acc    = acc_e'(acc_i);
  assign m_mode = priv_i[1];
  assign is_ss  = (acc_i < 3'd3);

  ss_page_decode i_page_decode (
    .xwr_i      (pte_xwr_i),
    .menv_sse_i (menv_sse_i),
    .henv_sse_i (henv_sse_i),
    .virt_i     (virt_i),
    .pg_o       (pg)
  );

  ss_ss_check #(.ADDR_LO_W(ADDR_LO_W)) i_ss_check (
    .acc_i     (acc),
    .pg_i      (pg),
    .paged_i   (paged_i),
    .m_mode_i  (m_mode),
    .virt_i    (virt_i),
    .g_act_i   (g_act_i),
    .g_r_i     (g_r_i),
    .g_w_i     (g_w_i),
    .pmp_r_i   (pmp_r_i),
    .pmp_w_i   (pmp_w_i),
    .idem_i    (pma_idem_i),
    .swap_ok_i (pma_swap_i),
    .xlen64_i  (xlen64_i),
    .addr_lo_i (addr_lo_i),
    .vd_o      (vd_ss)
  );

  ss_plain_check i_plain_check (
    .acc_i    (acc),
    .pg_i     (pg),
    .paged_i  (paged_i),
    .m_mode_i (m_mode),
    .vd_o     (vd_plain)
  );

  assign vd = is_ss ? vd_ss : vd_plain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      fault_o     <= 1'b0;
      cause_o     <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        fault_o <= vd.fault;
        cause_o <= vd.cause;
      end
    end
  end

  assert_rsp_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_no_rsp_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_hold_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(fault_o) && $stable(cause_o)));
  assert_no_fault_cause_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !fault_o) |-> cause_o == '0);
endmodule

// File: tb/test_ss_perm_chk.sv
module test_ss_perm_chk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] acc = '0, xwr = '0, addr = '0;
  logic [1:0] priv = '0;
  logic paged = 0, virt = 0, menv = 0, henv = 0, gact = 0, gr = 1, gw = 1;
  logic pmpr = 1, pmpw = 1, idem = 1, pswap = 1, x64 = 0;
  logic       rsp_valid, fault;
  logic [4:0] cause;

  int n_checks = 0, n_fail = 0;
  logic       e_fault;
  logic [4:0] e_cause;
  string      e_req;

  always #10 clk = ~clk;  // 50 MHz

  ss_perm_chk i_ss_perm_chk (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .acc_i(acc),
    .pte_xwr_i(xwr), .paged_i(paged), .priv_i(priv), .virt_i(virt),
    .menv_sse_i(menv), .henv_sse_i(henv), .g_act_i(gact), .g_r_i(gr),
    .g_w_i(gw), .pmp_r_i(pmpr), .pmp_w_i(pmpw), .pma_idem_i(idem),
    .pma_swap_i(pswap), .addr_lo_i(addr), .xlen64_i(x64),
    .rsp_valid_o(rsp_valid), .fault_o(fault), .cause_o(cause)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (acc=%0d xwr=%b paged=%0d priv=%0d virt=%0d me=%0d he=%0d addr=%0d x64=%0d)",
               req, act, exp, acc, xwr, paged, priv, virt, menv, henv, addr, x64);
    end
  endtask

  // expected verdict from the requirements
  task automatic model();
    logic ss_en, bad, sspg, ro, mm, ss_cls;
    ss_en  = menv && (!virt || henv);
    sspg   = (xwr == 3'b010) && ss_en;
    bad    = (xwr == 3'b000) || (!xwr[0] && xwr[1] && !sspg);
    ro     = (xwr == 3'b001);
    mm     = priv[1];
    ss_cls = acc < 3;
    e_fault = 1'b0; e_cause = 5'd0; e_req = "R10";
    if (ss_cls) begin
      if (acc != 3'd2 && ((x64 && addr != 0) || (!x64 && addr[1:0] != 0))) begin
        e_fault = 1; e_cause = 7; e_req = "R5";
      end else if (mm && acc == 3'd2) begin
        e_fault = 1; e_cause = 7; e_req = "R4";
      end else if (!mm && !paged) begin
        e_fault = 1; e_cause = 7; e_req = "R4";
      end else if (!mm && bad) begin
        e_fault = 1; e_cause = 15; e_req = "R2";
      end else if (!mm && ro) begin
        e_fault = 1; e_cause = 15; e_req = "R6";
      end else if (!mm && !sspg) begin
        e_fault = 1; e_cause = 7; e_req = "R6";
      end else if (!mm && virt && gact && !(gr && gw)) begin
        e_fault = 1; e_cause = 23; e_req = "R7";
      end else if (!(pmpr && pmpw) || !idem) begin
        e_fault = 1; e_cause = 7; e_req = "R8";
      end else if (acc == 3'd2 && !pswap) begin
        e_fault = 1; e_cause = 7; e_req = "R9";
      end else e_req = "R8";
    end else if (!mm && paged) begin
      if (bad) begin
        e_fault = 1; e_req = "R2";
        e_cause = (acc == 3'd3) ? 5'd13 : (acc == 3'd4) ? 5'd15 : 5'd12;
      end else if (sspg) begin
        e_req = "R3";
        if (acc == 3'd4) begin e_fault = 1; e_cause = 7; end
        else if (acc == 3'd5) begin e_fault = 1; e_cause = 1; end
      end
    end
  endtask

  task automatic one();
    @(negedge clk);
    req_valid = 1'b1;
    model();
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 valid", {5'd0, rsp_valid}, 6'd1);
    chk(e_req, {fault, cause}, {e_fault, e_cause});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {rsp_valid, fault, cause[3:0]}, 6'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", {5'd0, rsp_valid}, 6'd0);

    // page decode sweep: R2 R3 R4 R6 R10
    for (int c = 0; c < 6; c++)
      for (int t = 0; t < 8; t++)
        for (int pg = 0; pg < 2; pg++)
          for (int p = 0; p < 3; p++)
            for (int e = 0; e < 8; e++) begin
              acc = c[2:0]; xwr = t[2:0]; paged = pg[0];
              priv = (p == 2) ? 2'd3 : p[1:0];
              virt = e[0]; menv = e[1]; henv = e[2];
              one();
            end

    // permission sweep on a valid shadow-stack page: R7 R8 R9
    xwr = 3'b010; paged = 1; priv = 2'd1; virt = 1; menv = 1; henv = 1;
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 128; k++) begin
        acc = c[2:0];
        {gact, gr, gw, pmpr, pmpw, idem, pswap} = k[6:0];
        one();
      end

    // alignment sweep: R5
    gact = 0; gr = 1; gw = 1; pmpr = 1; pmpw = 1; idem = 1; pswap = 1;
    for (int c = 0; c < 3; c++)
      for (int w = 0; w < 2; w++)
        for (int a = 0; a < 8; a++) begin
          acc = c[2:0]; x64 = w[0]; addr = a[2:0];
          one();
        end
    x64 = 0; addr = 0;

    // outputs hold across idle cycles: R1
    acc = 3'd4; virt = 0;
    one();
    repeat (2) @(negedge clk);
    chk("R1 hold valid", {5'd0, rsp_valid}, 6'd0);
    chk("R1 hold verdict", {fault, cause}, {1'b1, 5'd7});

    finish_run();
  end
endmodule